// File: doc/BRIEF.md
# Parallel-Port Channel Interrupt Vector Register

This block is the interrupt vector register of a parallel-port channel. The CPU writes a five-bit vector base into it. Two internal units can ask for service: the channel control state machine and the data pipeline. When the CPU reads the register during an interrupt acknowledge cycle, the low three bits carry a live code that names the unit asking. The control state machine asks when the remote master turns the link around, in either direction. It also asks when the remote master sends an identification query during negotiation. The data pipeline asks through its own request line.

Each unit has a pending flag. A single-cycle event pulse sets the flag. The CPU clears the flag with a dedicated clear pulse. If an event and a clear arrive in the same cycle, the event wins and the flag stays set. The interrupt output is high while either flag is set. The source code is captured in the first cycle of an acknowledge cycle and held until that cycle ends, so requests that arrive later cannot change it.

The register sits in a banked space. It is reachable only while the bank select input holds zero. It can be read at any time, not only during an acknowledge.

Top module: `pport_vec_reg`

## Requirements
- R1: After reset, the vector base is 00000, neither flag is pending and `irq` is low, so a read returns 8'h00.
- R2: A write stores bits [7:3] of `reg_wdata` as the vector base, and later reads return those five bits unchanged in [7:3].
- R3: Bits [2:0] of a write are never stored. Outside an acknowledge cycle, bits [2:0] of `reg_rdata` are always 000.
- R4: While `svc_ack` is high, `reg_rdata` is {base, code}. The code is 100 when only the control unit is pending, 101 when only the pipeline is pending, 110 when both are pending and 000 when neither is pending.
- R5: A pulse on `ev_dir_flip` or on `ev_id_query` sets the control unit's pending flag.
- R6: A pulse on `pipe_req` sets the pipeline's pending flag.
- R7: `irq` is high exactly while at least one pending flag is set.
- R8: `ctl_clr` and `pipe_clr` each clear their own flag. An event in the same cycle as the clear leaves the flag set.
- R9: The code seen in the first cycle of an acknowledge stays the same for every cycle while `svc_ack` remains high, even if new requests arrive.
- R10: When `bank_sel` is not zero, writes leave the base unchanged and reads return 8'h00 (outside an acknowledge).
- R11: A normal read (`reg_sel`=1, `reg_wr`=0, bank zero, `svc_ack`=0) returns {base, 000} at any time, even when requests are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 7 | Current register bank; the register answers only in bank 0 |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_wdata | input | 8 | Write data; bits [7:3] form the base |
| reg_rdata | output | 8 | Read data, or the composed vector during an acknowledge |
| ev_dir_flip | input | 1 | Pulse: the remote master reversed the link direction |
| ev_id_query | input | 1 | Pulse: the remote master asked for identification |
| pipe_req | input | 1 | Pulse: the data pipeline needs service |
| ctl_clr | input | 1 | Pulse: clear the control unit's pending flag |
| pipe_clr | input | 1 | Pulse: clear the pipeline's pending flag |
| svc_ack | input | 1 | High for the whole interrupt acknowledge cycle |
| irq | output | 1 | Interrupt request |

## Verification
The code is driven through all four states of the two pending flags: none, control only, pipeline only, and both. This shows that each code belongs to the right unit and that the control-only and pipeline-only codes are not swapped. Acknowledges are held while a new request arrives, which separates a latched code from one that follows the flags live. Writes with all-ones low bits, writes to a foreign bank and clears that coincide with events each test whether one field or flag is touched when it must not be. On every cycle a behavioural model is compared with `reg_rdata` and `irq`.

// File: rtl/pvr_pkg.sv
package pvr_pkg;

    localparam int CODE_W = 3;

    typedef logic [CODE_W-1:0] src_code_t;

    localparam src_code_t CODE_NONE = 3'b000;
    localparam src_code_t CODE_CTL  = 3'b100;
    localparam src_code_t CODE_PIPE = 3'b101;
    localparam src_code_t CODE_BOTH = 3'b110;

    // Source index order in the pending vector
    localparam int SRC_PIPE = 0;
    localparam int SRC_CTL  = 1;
    localparam int N_SRC    = 2;

    function automatic src_code_t encode_src(input logic ctl, input logic pipe);
        src_code_t c;
        case ({ctl, pipe})
            2'b10:   c = CODE_CTL;
            2'b01:   c = CODE_PIPE;
            2'b11:   c = CODE_BOTH;
            default: c = CODE_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pvr_pend_bit.sv
module pvr_pend_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    typedef struct packed {
        logic pend;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)
            st_d.pend = 1'b0;
        if (set_i)
            st_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R8: an event that coincides with a clear keeps the flag set
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o);
    // R8: a lone clear drops the flag
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !pend_o);
    // R5: the flag rises only after an event
    p_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && !set_i) |=> !pend_o);

endmodule

// File: rtl/pvr_code_latch.sv
module pvr_code_latch
    import pvr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ack_i,
    input  src_code_t live_i,
    output src_code_t code_o
);
    typedef struct packed {
        logic      in_ack;
        src_code_t held;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.in_ack = ack_i;
        if (ack_i && !st_q.in_ack)
            st_d.held = live_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // First acknowledge cycle shows the live code; later cycles the captured one
    assign code_o = st_q.in_ack ? st_q.held : live_i;

    // R9: the code stays fixed for the whole acknowledge
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && $past(ack_i)) |-> $stable(code_o));

endmodule

// File: rtl/pvr_base_reg.sv
module pvr_base_reg #(
    parameter int VEC_W  = 8,
    parameter int CODE_W = 3,
    localparam int BASE_W = VEC_W - CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [BASE_W-1:0] wbase_i,
    output logic [BASE_W-1:0] base_o
);
    typedef struct packed {
        logic [BASE_W-1:0] base;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i)
            st_d.base = wbase_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign base_o = st_q.base;

    // R2: a write lands in the base on the next cycle
    p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (base_o == $past(wbase_i)));

endmodule

// File: rtl/pport_vec_reg.sv
module pport_vec_reg #(
    parameter int VEC_W     = 8,
    parameter int BANK_W    = 7,
    parameter int HOME_BANK = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [VEC_W-1:0]  reg_wdata,
    output logic [VEC_W-1:0]  reg_rdata,
    input  logic              ev_dir_flip,
    input  logic              ev_id_query,
    input  logic              pipe_req,
    input  logic              ctl_clr,
    input  logic              pipe_clr,
    input  logic              svc_ack,
    output logic              irq
);
    import pvr_pkg::*;

    localparam int BASE_W = VEC_W - CODE_W;

    logic [N_SRC-1:0] set_v, clr_v, pend_v;
    logic             bank_hit, wr_en, rd_en;
    logic [BASE_W-1:0] base_w;
    src_code_t        live_code, eff_code;

    assign set_v[SRC_CTL]  = ev_dir_flip | ev_id_query;
    assign set_v[SRC_PIPE] = pipe_req;
    assign clr_v[SRC_CTL]  = ctl_clr;
    assign clr_v[SRC_PIPE] = pipe_clr;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        pvr_pend_bit u_pend (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_v[g]),
            .clr_i  (clr_v[g]),
            .pend_o (pend_v[g])
        );
    end

    assign bank_hit = (bank_sel == BANK_W'(HOME_BANK));
    assign wr_en    = reg_sel &  reg_wr & bank_hit;
    assign rd_en    = reg_sel & ~reg_wr & bank_hit;

    pvr_base_reg #(.VEC_W(VEC_W), .CODE_W(CODE_W)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en),
        .wbase_i (reg_wdata[VEC_W-1:CODE_W]),
        .base_o  (base_w)
    );

    assign live_code = encode_src(pend_v[SRC_CTL], pend_v[SRC_PIPE]);

    pvr_code_latch u_code (
        .clk    (clk),
        .rst_n  (rst_n),
        .ack_i  (svc_ack),
        .live_i (live_code),
        .code_o (eff_code)
    );

    always_comb begin
        reg_rdata = '0;
        if (svc_ack)
            reg_rdata = {base_w, eff_code};
        else if (rd_en)
            reg_rdata = {base_w, CODE_NONE};
    end

    assign irq = |pend_v;

    // R3: low bits are quiet outside acknowledge
    p_low_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !svc_ack |-> (reg_rdata[CODE_W-1:0] == '0));
    // R10: foreign-bank writes leave the base alone
    p_foreign_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && (bank_sel != BANK_W'(HOME_BANK))) |=> $stable(base_w));
    // R10: foreign-bank reads return zero
    p_foreign_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && !reg_wr && !svc_ack && (bank_sel != BANK_W'(HOME_BANK)))
            |-> (reg_rdata == '0));
    // R4: only the four legal codes appear during acknowledge
    p_code_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ack |-> (reg_rdata[CODE_W-1:0] == CODE_NONE || reg_rdata[CODE_W-1:0] == CODE_CTL
                  || reg_rdata[CODE_W-1:0] == CODE_PIPE || reg_rdata[CODE_W-1:0] == CODE_BOTH));
    // R7: no interrupt without a preceding request
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !ev_dir_flip && !ev_id_query && !pipe_req) |=> !irq);

endmodule

// File: tb/sim_pport_vec_reg.sv
`timescale 1ns/1ps
module sim_pport_vec_reg;

    logic       clk = 0;
    logic       rst_n = 0;
    logic [6:0] bank_sel = '0;
    logic       reg_sel = 0, reg_wr = 0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ev_dir_flip = 0, ev_id_query = 0, pipe_req = 0;
    logic       ctl_clr = 0, pipe_clr = 0, svc_ack = 0;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pport_vec_reg u0 (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_dir_flip(ev_dir_flip), .ev_id_query(ev_id_query), .pipe_req(pipe_req),
        .ctl_clr(ctl_clr), .pipe_clr(pipe_clr), .svc_ack(svc_ack), .irq(irq)
    );

    // Behavioural reference model
    bit       m_ctl, m_pipe, m_ackp;
    bit [4:0] m_base;
    bit [2:0] m_code;

    function automatic bit [2:0] m_live(bit c, bit p);
        if (c && p) return 3'd6;
        if (c)      return 3'd4;
        if (p)      return 3'd5;
        return 3'd0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctl = 0; m_pipe = 0; m_ackp = 0; m_base = 0; m_code = 0;
        end else begin
            if (svc_ack && !m_ackp) m_code = m_live(m_ctl, m_pipe);
            m_ackp = svc_ack;
            if (reg_sel && reg_wr && bank_sel == 0) m_base = reg_wdata[7:3];
            if (ctl_clr)  m_ctl = 0;
            if (ev_dir_flip || ev_id_query) m_ctl = 1;
            if (pipe_clr) m_pipe = 0;
            if (pipe_req) m_pipe = 1;
        end
    end

    function automatic bit [7:0] m_rdata();
        bit [2:0] lo;
        lo = svc_ack ? (m_ackp ? m_code : m_live(m_ctl, m_pipe)) : 3'd0;
        if (svc_ack || (reg_sel && !reg_wr && bank_sel == 0)) return {m_base, lo};
        return 8'h00;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 model rdata", reg_rdata, m_rdata());
            chk("R7 model irq", {7'd0, irq}, {7'd0, (m_ctl | m_pipe)});
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(logic [7:0] v);
        reg_sel = 1; reg_wr = 1; reg_wdata = v;
        step();
        reg_sel = 0; reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic rd(string tag, logic [7:0] exp);
        reg_sel = 1; reg_wr = 0;
        @(negedge clk);
        chk(tag, reg_rdata, exp);
        step();
        reg_sel = 0;
    endtask

    task automatic see_irq(string tag, logic exp);
        @(negedge clk);
        chk(tag, {7'd0, irq}, {7'd0, exp});
        step();
    endtask

    task automatic ack_see(string tag, logic [7:0] exp);
        svc_ack = 1;
        @(negedge clk);
        chk(tag, reg_rdata, exp);
        step();
        svc_ack = 0;
        step();
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1;
        step();
        rd("R1 reset read", 8'h00);
        see_irq("R1 reset irq", 0);

        wr(8'hFF);
        rd("R2 base all ones", 8'hF8);
        wr(8'hA5);
        rd("R3 low bits dropped", 8'hA0);

        bank_sel = 7'd1;
        wr(8'h18);
        rd("R10 foreign bank read", 8'h00);
        bank_sel = 7'd0;
        rd("R10 base untouched", 8'hA0);

        ev_dir_flip = 1; step(); ev_dir_flip = 0;
        see_irq("R5 direction flip raises irq", 1);

        svc_ack = 1;
        @(negedge clk);
        chk("R4 control code", reg_rdata, 8'hA4);
        step();
        pipe_req = 1; step(); pipe_req = 0;
        @(negedge clk);
        chk("R9 code held in ack", reg_rdata, 8'hA4);
        step();
        svc_ack = 0;
        step();
        rd("R11 plain read while pending", 8'hA0);

        ack_see("R4 both code", 8'hA6);

        ctl_clr = 1; step(); ctl_clr = 0;
        see_irq("R8 pipe still pending", 1);
        ack_see("R6 pipe code", 8'hA5);

        pipe_clr = 1; pipe_req = 1; step(); pipe_clr = 0; pipe_req = 0;
        see_irq("R8 event beats clear", 1);
        pipe_clr = 1; step(); pipe_clr = 0;
        see_irq("R7 irq low when idle", 0);

        ev_id_query = 1; step(); ev_id_query = 0;
        see_irq("R5 id query raises irq", 1);
        ack_see("R4 id query code", 8'hA4);
        ctl_clr = 1; ev_id_query = 1; step(); ctl_clr = 0; ev_id_query = 0;
        see_irq("R8 control event beats clear", 1);
        ctl_clr = 1; step(); ctl_clr = 0;
        see_irq("R8 control cleared", 0);

        ack_see("R4 none code", 8'hA0);

        wr(8'h07);
        rd("R3 zero base low ones", 8'h00);

        step(2);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule